// File: doc/BRIEF.md
# PLL Control and Lock-Change Status Register

This block is one 8-bit control and status register of a clock generator. It sits on a simple synchronous register bus with an address, a read strobe, a write strobe, write data and combinational read data. Software uses it to switch the PLL on and off and to choose the base clock. It also exposes a flag that records each change in the PLL lock state, and it raises an interrupt from that flag.

The lock input comes in asynchronously. It passes through a synchronizer chain, and a registered copy of the synchronized value is compared with the current value to find toggles. A neighbouring bandwidth register supplies an automatic-mode input. While that input is low, the interrupt enable and the flag are held cleared and cannot be written.

All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake and no back-pressure.

Top module: `pll_ctrl_reg`

## Requirements
- R1: Out of reset, a read returns 0x2F. The bit layout is: bit 7 = interrupt enable, bit 6 = lock-change flag, bit 5 = PLL on, bit 4 = clock select. Bits 3..0 always read 1. After reset `pll_on_o`=1, `clk_sel_o`=0 and `irq_o`=0.
- R2: A write with automatic mode on updates bit 7 (enable), bit 5 (`pll_on_o`) and bit 4 (`clk_sel_o`) from the write data at the clock edge that ends the write cycle.
- R3: Each toggle of `lock_i`, rising or falling, sets the flag. The flag is readable at the third rising clock edge after the input changes.
- R4: A read of the register clears the flag at the edge that ends the read cycle. The value returned in that cycle is the flag value before the clear.
- R5: `irq_o` is registered and equals enable AND flag. It falls in the cycle right after a clearing read.
- R6: Writes to bit 6 and to bits 3..0 have no effect.
- R7: While `auto_bw_i`=0, bits 7 and 6 read 0, writes to bit 7 are ignored, and enable and flag are held cleared. When the mode returns to 1, there is no stale enable, flag or interrupt.
- R8: The register answers only at bus address 0x38. A read at any other address returns 0x00 and leaves the flag untouched. A write at any other address changes nothing.
- R9: If a lock toggle and a clearing read fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Bus address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, nonzero only on a read hit |
| lock_i | input | 1 | Asynchronous PLL lock status |
| auto_bw_i | input | 1 | Automatic bandwidth mode from the neighbouring register |
| pll_on_o | output | 1 | PLL enable |
| clk_sel_o | output | 1 | Base clock select |
| irq_o | output | 1 | Lock-change interrupt request |

## Verification
Read data is combinational, so the bench samples it in the same cycle the strobe is driven. Flag clears, writes and the interrupt take effect at the edge that ends the bus cycle, so those checks sample at the following falling edge. A lock toggle needs three rising edges before the flag, and with it `irq_o`, can be seen. The bench therefore waits exactly three edges before it looks. For the same-cycle case it places the read so that its closing edge is that third edge. Bus inputs are driven 2 ns after a rising edge, and outputs are sampled at the falling edge, so no check depends on the order of processes at an edge.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_IE     = 7;
  localparam int BIT_FLAG   = 6;
  localparam int BIT_PLLON  = 5;
  localparam int BIT_CSEL   = 4;
  localparam int UNIMP_W    = 4;
  typedef struct packed {
    logic               ie;
    logic               flag;
    logic               pll_on;
    logic               csel;
    logic [UNIMP_W-1:0] unimp;
  } pctl_view_t;
endpackage

// File: rtl/pctl_sync.sv
module pctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;
  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate
  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pctl_toggle.sv
module pctl_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic toggle_o
);
  logic lvl_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl_i;
  assign toggle_o = lvl_i ^ lvl_d;
endmodule

// File: rtl/pctl_core.sv
module pctl_core
  import pctl_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              toggle_i,
  input  logic              auto_i,
  output logic              ie_o,
  output logic              flag_o,
  output logic              pll_on_o,
  output logic              csel_o,
  output logic              irq_o
);
  logic rd_hit, wr_hit;
  logic ie_q, flag_q, pll_q, csel_q, irq_q;
  logic ie_n, flag_n;
  pctl_view_t view;

  assign rd_hit = rd_i && (addr_i == REG_ADDR);
  assign wr_hit = wr_i && (addr_i == REG_ADDR);

  always_comb begin
    ie_n   = 1'b0;
    flag_n = 1'b0;
    if (auto_i) begin
      ie_n   = wr_hit ? wdata_i[BIT_IE] : ie_q;
      flag_n = toggle_i | (flag_q & ~rd_hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      pll_q  <= 1'b1;
      csel_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ie_q   <= ie_n;
      flag_q <= flag_n;
      irq_q  <= ie_n & flag_n;
      if (wr_hit) begin
        pll_q  <= wdata_i[BIT_PLLON];
        csel_q <= wdata_i[BIT_CSEL];
      end
    end

  always_comb begin
    view.ie     = ie_q & auto_i;
    view.flag   = flag_q & auto_i;
    view.pll_on = pll_q;
    view.csel   = csel_q;
    view.unimp  = '1;
  end

  assign rdata_o  = rd_hit ? view : '0;
  assign ie_o     = ie_q;
  assign flag_o   = flag_q;
  assign pll_on_o = pll_q;
  assign csel_o   = csel_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg #(
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h38,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              lock_i,
  input  logic              auto_bw_i,
  output logic              pll_on_o,
  output logic              clk_sel_o,
  output logic              irq_o
);
  logic lock_s, lock_tgl, ie_st, flag_st;

  pctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(lock_i), .q_o(lock_s)
  );

  pctl_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .lvl_i(lock_s), .toggle_o(lock_tgl)
  );

  pctl_core #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_core (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .toggle_i(lock_tgl),
    .auto_i(auto_bw_i), .ie_o(ie_st), .flag_o(flag_st),
    .pll_on_o(pll_on_o), .csel_o(clk_sel_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/pll_ctrl_reg_chk.sv
module pll_ctrl_reg_chk #(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h38
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [7:0]        rdata_o,
  input logic              auto_bw_i,
  input logic              lock_tgl,
  input logic              ie_st,
  input logic              flag_st,
  input logic              irq_o
);
  logic hit_rd;
  assign hit_rd = rd_i && (addr_i == REG_ADDR);

  p_unimpl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rd |-> (rdata_o[3:0] == 4'hF));
  p_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_rd |-> (rdata_o == 8'h00));
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_tgl && auto_bw_i) |=> flag_st);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_rd && !lock_tgl) |=> !flag_st);
  p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (ie_st && flag_st));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_bw_i |=> (!ie_st && !flag_st && !irq_o));
endmodule

bind pll_ctrl_reg pll_ctrl_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .rdata_o(rdata_o), .auto_bw_i(auto_bw_i), .lock_tgl(lock_tgl),
  .ie_st(ie_st), .flag_st(flag_st), .irq_o(irq_o)
);

// File: tb/pll_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module pll_ctrl_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic lock_i = 1'b0, auto_bw_i = 1'b1;
  logic pll_on_o, clk_sel_o, irq_o;
  int checks = 0, errors = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  pll_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lock_i(lock_i),
    .auto_bw_i(auto_bw_i), .pll_on_o(pll_on_o), .clk_sel_o(clk_sel_o),
    .irq_o(irq_o)
  );

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (rd_i && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata_o !== it.exp) begin
        errors++;
        $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata_o, it.exp);
      end
    end
  end

  task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk); #2;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    addr_i = a; rd_i = 1'b1;
    @(posedge clk); #2;
    rd_i = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk); #2;
    wr_i = 1'b0;
  endtask

  task automatic pin_chk(input logic act, input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pin actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // flip lock, then wait the three edges the flag needs
  task automatic lock_flip_settle();
    @(posedge clk); #2;
    lock_i = ~lock_i;
    repeat (3) @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    pin_chk(irq_o, 1'b0, "R1 irq");
    pin_chk(pll_on_o, 1'b1, "R1 pll_on");
    pin_chk(clk_sel_o, 1'b0, "R1 clk_sel");
    bus_read(8'h38, 8'h2F, "R1 reset value");
    // R2 and R6 writes
    bus_write(8'h38, 8'hFF);
    bus_read(8'h38, 8'hBF, "R2 R6 write all ones");
    pin_chk(clk_sel_o, 1'b1, "R2 clk_sel set");
    bus_write(8'h38, 8'h00);
    bus_read(8'h38, 8'h0F, "R2 write zeros");
    pin_chk(pll_on_o, 1'b0, "R2 pll_on cleared");
    bus_write(8'h39, 8'hFF);
    bus_read(8'h38, 8'h0F, "R8 write elsewhere ignored");
    bus_write(8'h38, 8'hA0);
    bus_read(8'h38, 8'hAF, "R2 enable and pll on");
    // R3 rising toggle, R5 irq, R4 clear
    lock_flip_settle();
    pin_chk(irq_o, 1'b1, "R5 irq on flag");
    bus_read(8'h38, 8'hEF, "R3 rising toggle sets flag");
    pin_chk(irq_o, 1'b0, "R5 irq drops after read");
    bus_read(8'h38, 8'hAF, "R4 flag cleared by read");
    // R3 falling toggle, R8 other address
    lock_flip_settle();
    bus_read(8'h39, 8'h00, "R8 other address reads zero");
    bus_read(8'h38, 8'hEF, "R8 R3 flag kept after miss read");
    pin_chk(irq_o, 1'b0, "R5 irq low after clear");
    // R9 same-cycle toggle and read
    @(posedge clk); #2;
    lock_i = ~lock_i;
    @(posedge clk);
    bus_read(8'h38, 8'hAF, "R9 read in toggle cycle");
    bus_read(8'h38, 8'hEF, "R9 flag survives clear");
    // R7 auto mode off
    @(posedge clk); #2 auto_bw_i = 1'b0;
    lock_flip_settle();
    pin_chk(irq_o, 1'b0, "R7 no irq when off");
    bus_read(8'h38, 8'h2F, "R7 enable and flag read zero");
    bus_write(8'h38, 8'h80);
    bus_read(8'h38, 8'h0F, "R7 enable write ignored");
    @(posedge clk); #2 auto_bw_i = 1'b1;
    repeat (2) @(posedge clk);
    bus_read(8'h38, 8'h0F, "R7 no stale state on return");
    pin_chk(irq_o, 1'b0, "R7 no stale irq");
    bus_write(8'h38, 8'hC0);
    bus_read(8'h38, 8'h8F, "R6 flag bit write ignored");
    pin_chk(irq_o, 1'b0, "R6 no irq from write");
    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule